// File: doc/BRIEF.md
# Parity Error Injection Controller

This block handles parity protection and test-time error injection for an instruction cache. It computes one check bit per 64-bit data chunk and one check bit per metadata word on refill. It checks lines read back against their stored check bits. It also drives the check-enable level that the cache pipelines sample.

Software reaches the block through a small register window: a control register and a target physical address register. Writing the control register with the inject bit set starts a sequence. The block looks up the target address in the cache. On a hit it writes back the check bits of the chosen array, computed from the looked-up contents with a poison bit that inverts them, so that the next read of that line reports an error. Software polls a two-bit status field to learn whether the injection succeeded or failed. The SRAM arrays are outside the block and are reached through a lookup handshake and a check-bit write handshake.

Top module: `par_inj_ctrl`

## Requirements
- R1: After reset the control and target registers read as zero, check_en_o is low, and lkp_req_o and pw_req_o are low.
- R2: rf_data_code_o[i] is the XOR of the 64 bits rf_data_i[64*i+63:64*i], and rf_meta_code_o is the XOR of all bits of rf_meta_i. No poison is applied on this path.
- R3: rd_data_err_o[i] is the XOR of chunk i of rd_data_i and rd_data_code_i[i], and rd_meta_err_o is the XOR of rd_meta_i and rd_meta_code_i. Both are forced to 0 while check_en_o is low.
- R4: The control register at byte offset 0 has the following fields: bit 0 is the check enable and drives check_en_o; bit 1 is the inject request; bits 3:2 select the target (0 = metadata, 1 = data); bits 6:5 are the read-only status (0 = busy, 1 = success, 2 = failure). The target address register at offset 8 holds bits PA_W-1:0. All other bits read 0.
- R5: Writes to the status bits, to unused bits, or to any offset other than 0 and 8 have no effect.
- R6: A control write with bit 1 set, check enable set and target 0 or 1 clears the status to 0 and raises lkp_req_o with lkp_addr_o equal to the target register. Both hold until lkp_ack_i.
- R7: When lkp_ack_i arrives with lkp_hit_i high, pw_req_o rises with pw_sel_o equal to target bit 0. For a data target, pw_code_o[i] is the inverted parity of chunk i of lkp_data_i. For a metadata target, pw_code_o[0] is the inverted parity of lkp_meta_i and the other bits are 0. These are held until pw_ack_i, after which the status reads 1 and bit 1 reads 0.
- R8: When lkp_ack_i arrives with lkp_hit_i low, no write is issued, the status reads 2 and bit 1 reads 0.
- R9: A control write with bit 1 set and either bit 0 clear or a target value of 2 or 3 sets the status to 2 and clears bit 1 at once, with no lookup.
- R10: While an injection is in progress, writes to either register are ignored. The control register then reads bit 1 set with status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Register access is a write |
| reg_addr_i | input | REG_AW | Register byte offset |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data (combinational) |
| check_en_o | output | 1 | Check enable to cache pipelines |
| rf_data_i | input | DATA_W | Refill line data |
| rf_meta_i | input | META_W | Refill metadata |
| rf_data_code_o | output | DATA_W/CHUNK_W | Refill data check bits |
| rf_meta_code_o | output | 1 | Refill metadata check bit |
| rd_data_i | input | DATA_W | Read line data |
| rd_data_code_i | input | DATA_W/CHUNK_W | Stored data check bits |
| rd_meta_i | input | META_W | Read metadata |
| rd_meta_code_i | input | 1 | Stored metadata check bit |
| rd_data_err_o | output | DATA_W/CHUNK_W | Per-chunk data parity error |
| rd_meta_err_o | output | 1 | Metadata parity error |
| lkp_req_o | output | 1 | Target lookup request |
| lkp_addr_o | output | PA_W | Target physical address |
| lkp_ack_i | input | 1 | Lookup done |
| lkp_hit_i | input | 1 | Lookup hit, valid with lkp_ack_i |
| lkp_data_i | input | DATA_W | Hit line data, valid with lkp_ack_i |
| lkp_meta_i | input | META_W | Hit metadata, valid with lkp_ack_i |
| pw_req_o | output | 1 | Poisoned check-bit write request |
| pw_sel_o | output | 1 | Array to write: 0 metadata, 1 data |
| pw_code_o | output | DATA_W/CHUNK_W | Check bits to write |
| pw_ack_i | input | 1 | Check-bit write done |

## Verification
Register writes from software can land in the same cycle as the injection sequence's lookup or write handshake. The bench provokes this by writing both registers while the lookup is pending and by holding the acknowledges back for several cycles. It then judges the result through register readback and through lkp_addr_o, both of which must stay unchanged. It also sweeps every combination of check enable, target code and hit or miss. Each outcome is compared against a status, request bit and poisoned code that the bench computes from the looked-up contents.

// File: rtl/par_inj_pkg.sv
package par_inj_pkg;
  localparam int unsigned CTRL_OFF = 0;
  localparam int unsigned ADDR_OFF = 8;

  localparam int unsigned EN_BIT  = 0;
  localparam int unsigned REQ_BIT = 1;
  localparam int unsigned TGT_LSB = 2;
  localparam int unsigned ST_LSB  = 5;

  localparam logic [1:0] ST_BUSY = 2'd0;
  localparam logic [1:0] ST_OK   = 2'd1;
  localparam logic [1:0] ST_FAIL = 2'd2;

  localparam logic [1:0] TGT_META = 2'd0;
  localparam logic [1:0] TGT_DATA = 2'd1;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LKP  = 2'd1,
    S_WR   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/par_enc.sv
module par_enc #(
  parameter int unsigned W  = 512,
  parameter int unsigned CW = 64,
  localparam int unsigned N = W / CW
) (
  input  logic [W-1:0] data_i,
  input  logic         poison_i,
  output logic [N-1:0] code_o
);
  for (genvar g = 0; g < N; g++) begin : g_chunk
    assign code_o[g] = (^data_i[g*CW +: CW]) ^ poison_i;
  end
endmodule

// File: rtl/par_chk.sv
module par_chk #(
  parameter int unsigned W  = 512,
  parameter int unsigned CW = 64,
  localparam int unsigned N = W / CW
) (
  input  logic [W-1:0] data_i,
  input  logic [N-1:0] code_i,
  input  logic         en_i,
  output logic [N-1:0] err_o
);
  for (genvar g = 0; g < N; g++) begin : g_chunk
    assign err_o[g] = en_i & ((^data_i[g*CW +: CW]) ^ code_i[g]);
  end
endmodule

// File: rtl/par_inj_seq.sv
module par_inj_seq
  import par_inj_pkg::*;
#(
  parameter int unsigned PA_W   = 48,
  parameter int unsigned NCH    = 8,
  parameter int unsigned REG_AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o,
  output logic              check_en_o,
  output logic              lkp_req_o,
  output logic [PA_W-1:0]   lkp_addr_o,
  input  logic              lkp_ack_i,
  input  logic              lkp_hit_i,
  input  logic [NCH-1:0]    data_pz_i,
  input  logic              meta_pz_i,
  output logic              pw_req_o,
  output logic              pw_sel_o,
  output logic [NCH-1:0]    pw_code_o,
  input  logic              pw_ack_i
);
  seq_state_e      state_q;
  logic            en_q, req_q;
  logic [1:0]      tgt_q, st_q;
  logic [PA_W-1:0] addr_q;
  logic [NCH-1:0]  code_q, code_sel;

  logic sel_ctrl, sel_addr, wr_ctrl, wr_addr, new_en, new_req, start_bad;
  logic [1:0] new_tgt;
  logic wdata_unused;

  assign sel_ctrl = reg_addr_i == REG_AW'(CTRL_OFF);
  assign sel_addr = reg_addr_i == REG_AW'(ADDR_OFF);
  // writes only land while idle
  assign wr_ctrl  = reg_req_i & reg_we_i & sel_ctrl & (state_q == S_IDLE);
  assign wr_addr  = reg_req_i & reg_we_i & sel_addr & (state_q == S_IDLE);
  assign new_en   = reg_wdata_i[EN_BIT];
  assign new_req  = reg_wdata_i[REQ_BIT];
  assign new_tgt  = reg_wdata_i[TGT_LSB +: 2];
  assign start_bad = !new_en || (new_tgt != TGT_META && new_tgt != TGT_DATA);
  assign wdata_unused = ^reg_wdata_i;

  always_comb begin
    code_sel = '0;
    if (tgt_q == TGT_DATA) code_sel = data_pz_i;
    else                   code_sel[0] = meta_pz_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      en_q    <= 1'b0;
      req_q   <= 1'b0;
      tgt_q   <= '0;
      st_q    <= ST_BUSY;
      addr_q  <= '0;
      code_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (wr_addr) addr_q <= reg_wdata_i[PA_W-1:0];
          if (wr_ctrl) begin
            en_q  <= new_en;
            tgt_q <= new_tgt;
            if (new_req) begin
              if (start_bad) begin
                st_q  <= ST_FAIL;
                req_q <= 1'b0;
              end else begin
                st_q    <= ST_BUSY;
                req_q   <= 1'b1;
                state_q <= S_LKP;
              end
            end
          end
        end
        S_LKP: begin
          if (lkp_ack_i) begin
            if (lkp_hit_i) begin
              code_q  <= code_sel;
              state_q <= S_WR;
            end else begin
              st_q    <= ST_FAIL;
              req_q   <= 1'b0;
              state_q <= S_IDLE;
            end
          end
        end
        S_WR: begin
          if (pw_ack_i) begin
            st_q    <= ST_OK;
            req_q   <= 1'b0;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_req_i && !reg_we_i) begin
      if (sel_ctrl) begin
        reg_rdata_o[EN_BIT]        = en_q;
        reg_rdata_o[REQ_BIT]       = req_q;
        reg_rdata_o[TGT_LSB +: 2]  = tgt_q;
        reg_rdata_o[ST_LSB +: 2]   = st_q;
      end else if (sel_addr) begin
        reg_rdata_o[PA_W-1:0] = addr_q;
      end
    end
  end

  assign check_en_o = en_q;
  assign lkp_req_o  = state_q == S_LKP;
  assign lkp_addr_o = addr_q;
  assign pw_req_o   = state_q == S_WR;
  assign pw_sel_o   = tgt_q[0];
  assign pw_code_o  = code_q;

  // R6
  lkp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_req_o && !lkp_ack_i |=> lkp_req_o && $stable(lkp_addr_o));
  // R7
  pw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pw_req_o && !pw_ack_i |=> pw_req_o && $stable(pw_code_o));
  // R7
  ok_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OK) && !$stable(st_q) |-> $past(pw_ack_i));
  // R10
  busy_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_req_o || pw_req_o) |-> req_q && (st_q == ST_BUSY));
  // R8
  fail_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FAIL) |-> !req_q && !pw_req_o);
endmodule

// File: rtl/par_inj_ctrl.sv
module par_inj_ctrl #(
  parameter int unsigned DATA_W  = 512,
  parameter int unsigned CHUNK_W = 64,
  parameter int unsigned META_W  = 40,
  parameter int unsigned PA_W    = 48,
  parameter int unsigned REG_AW  = 4,
  localparam int unsigned NCH    = DATA_W / CHUNK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o,
  output logic              check_en_o,
  input  logic [DATA_W-1:0] rf_data_i,
  input  logic [META_W-1:0] rf_meta_i,
  output logic [NCH-1:0]    rf_data_code_o,
  output logic              rf_meta_code_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [NCH-1:0]    rd_data_code_i,
  input  logic [META_W-1:0] rd_meta_i,
  input  logic              rd_meta_code_i,
  output logic [NCH-1:0]    rd_data_err_o,
  output logic              rd_meta_err_o,
  output logic              lkp_req_o,
  output logic [PA_W-1:0]   lkp_addr_o,
  input  logic              lkp_ack_i,
  input  logic              lkp_hit_i,
  input  logic [DATA_W-1:0] lkp_data_i,
  input  logic [META_W-1:0] lkp_meta_i,
  output logic              pw_req_o,
  output logic              pw_sel_o,
  output logic [NCH-1:0]    pw_code_o,
  input  logic              pw_ack_i
);
  logic [NCH-1:0] data_pz;
  logic [0:0]     meta_pz, rf_mcode, rd_merr;

  par_enc #(.W(DATA_W), .CW(CHUNK_W)) u_rf_denc (
    .data_i(rf_data_i), .poison_i(1'b0), .code_o(rf_data_code_o));
  par_enc #(.W(META_W), .CW(META_W)) u_rf_menc (
    .data_i(rf_meta_i), .poison_i(1'b0), .code_o(rf_mcode));
  par_enc #(.W(DATA_W), .CW(CHUNK_W)) u_pz_denc (
    .data_i(lkp_data_i), .poison_i(1'b1), .code_o(data_pz));
  par_enc #(.W(META_W), .CW(META_W)) u_pz_menc (
    .data_i(lkp_meta_i), .poison_i(1'b1), .code_o(meta_pz));

  par_chk #(.W(DATA_W), .CW(CHUNK_W)) u_rd_dchk (
    .data_i(rd_data_i), .code_i(rd_data_code_i), .en_i(check_en_o), .err_o(rd_data_err_o));
  par_chk #(.W(META_W), .CW(META_W)) u_rd_mchk (
    .data_i(rd_meta_i), .code_i(rd_meta_code_i), .en_i(check_en_o), .err_o(rd_merr));

  assign rf_meta_code_o = rf_mcode[0];
  assign rd_meta_err_o  = rd_merr[0];

  par_inj_seq #(.PA_W(PA_W), .NCH(NCH), .REG_AW(REG_AW)) u_seq (
    .clk_i, .rst_ni, .reg_req_i, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .check_en_o, .lkp_req_o, .lkp_addr_o, .lkp_ack_i, .lkp_hit_i,
    .data_pz_i(data_pz), .meta_pz_i(meta_pz[0]),
    .pw_req_o, .pw_sel_o, .pw_code_o, .pw_ack_i);

  // R3
  err_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !check_en_o |-> (rd_data_err_o == '0) && !rd_meta_err_o);
endmodule

// File: tb/tb_par_inj_ctrl.sv
module tb_par_inj_ctrl;
  localparam int DW = 128, CWB = 64, MW = 8, PAW = 16, AW = 4, NC = DW / CWB;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic reg_req = 0, reg_we = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic check_en;
  logic [DW-1:0] rf_data = '0, rd_data = '0, lkp_data = '0;
  logic [MW-1:0] rf_meta = '0, rd_meta = '0, lkp_meta = '0;
  logic [NC-1:0] rf_dcode, rd_dcode = '0, rd_derr, pw_code;
  logic rf_mcode, rd_mcode = 0, rd_merr;
  logic lkp_req, lkp_ack = 0, lkp_hit = 0, pw_req, pw_sel, pw_ack = 0;
  logic [PAW-1:0] lkp_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  par_inj_ctrl #(.DATA_W(DW), .CHUNK_W(CWB), .META_W(MW), .PA_W(PAW), .REG_AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .check_en_o(check_en),
    .rf_data_i(rf_data), .rf_meta_i(rf_meta), .rf_data_code_o(rf_dcode), .rf_meta_code_o(rf_mcode),
    .rd_data_i(rd_data), .rd_data_code_i(rd_dcode), .rd_meta_i(rd_meta), .rd_meta_code_i(rd_mcode),
    .rd_data_err_o(rd_derr), .rd_meta_err_o(rd_merr),
    .lkp_req_o(lkp_req), .lkp_addr_o(lkp_addr), .lkp_ack_i(lkp_ack), .lkp_hit_i(lkp_hit),
    .lkp_data_i(lkp_data), .lkp_meta_i(lkp_meta),
    .pw_req_o(pw_req), .pw_sel_o(pw_sel), .pw_code_o(pw_code), .pw_ack_i(pw_ack));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
  endtask

  task automatic reg_rd(input logic [AW-1:0] a, output logic [63:0] d);
    reg_req = 1; reg_we = 0; reg_addr = a;
    #1 d = reg_rdata;
    reg_req = 0;
  endtask

  function automatic logic [DW-1:0] mkdata(input int s);
    logic [DW-1:0] v;
    for (int k = 0; k < DW / 32; k++) v[k*32 +: 32] = 32'(s * 32'h9E3779B1 + k * 32'h7F4A7C15 + (s << k));
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    logic [NC-1:0] expc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    reg_rd(0, rd);  check("R1 ctrl", rd, 0);
    reg_rd(8, rd);  check("R1 addr", rd, 0);
    check("R1 check_en", check_en, 0);
    check("R1 reqs", {lkp_req, pw_req}, 0);

    // R2 encoder sweep
    for (int m = 0; m < 256; m++) begin
      rf_meta = MW'(m);
      #1 check("R2 meta code", rf_mcode, ^MW'(m));
    end
    for (int s = 0; s < 40; s++) begin
      rf_data = mkdata(s);
      #1;
      for (int c = 0; c < NC; c++) expc[c] = ^rf_data[c*CWB +: CWB];
      check("R2 data code", rf_dcode, expc);
    end

    // R3 checker disabled then enabled
    for (int e = 0; e < 2; e++) begin
      if (e == 1) reg_wr(0, 64'h1);
      for (int m = 0; m < 256; m++) begin
        for (int k = 0; k < 2; k++) begin
          rd_meta = MW'(m); rd_mcode = k[0];
          #1 check("R3 meta err", rd_merr, e[0] & (^MW'(m) ^ k[0]));
        end
      end
      for (int s = 0; s < 16; s++) begin
        rd_data = mkdata(s + 100); rd_dcode = NC'(s);
        #1;
        for (int c = 0; c < NC; c++) expc[c] = e[0] & (^rd_data[c*CWB +: CWB] ^ rd_dcode[c]);
        check("R3 data err", rd_derr, expc);
      end
    end

    // R4 register map
    reg_wr(8, 64'hFFFF_0000_0000_ABCD);
    reg_rd(8, rd); check("R4 addr rw", rd, 64'hABCD);
    reg_wr(0, 64'h0D);
    reg_rd(0, rd); check("R4 ctrl rw", rd, 64'h0D);
    check("R4 check_en", check_en, 1);
    // R5 read-only and unmapped
    reg_wr(0, 64'hFFFF_FFFF_FFFF_FF65);
    reg_rd(0, rd); check("R5 ro bits", rd, 64'h05);
    reg_wr(4, 64'h0);
    reg_wr(12, 64'h0);
    reg_rd(0, rd); check("R5 off4 ctrl", rd, 64'h05);
    reg_rd(8, rd); check("R5 off4 addr", rd, 64'hABCD);
    reg_rd(12, rd); check("R5 off12 read", rd, 0);

    // injection sweep
    for (int en = 0; en < 2; en++)
      for (int tg = 0; tg < 4; tg++)
        for (int hit = 0; hit < 2; hit++) begin
          logic [PAW-1:0] pa;
          pa = PAW'(16'h1230 + en * 64 + tg * 8 + hit);
          reg_wr(8, 64'(pa));
          reg_wr(0, 64'(tg << 2) | 64'h2 | 64'(en));
          if (en == 0 || tg > 1) begin
            // R9
            reg_rd(0, rd);
            check("R9 fail status", rd, 64'h40 | 64'(tg << 2) | 64'(en));
            check("R9 no lookup", lkp_req, 0);
          end else begin
            // R6
            check("R6 lkp_req", lkp_req, 1);
            check("R6 lkp_addr", lkp_addr, 64'(pa));
            reg_rd(0, rd); check("R6 busy status", rd, 64'(tg << 2) | 64'h3);
            // R10 writes during busy
            reg_wr(0, 64'h0);
            reg_wr(8, 64'h0);
            reg_rd(0, rd); check("R10 ctrl kept", rd, 64'(tg << 2) | 64'h3);
            reg_rd(8, rd); check("R10 addr kept", rd, 64'(pa));
            check("R6 lkp hold", {lkp_req, lkp_addr}, {1'b1, pa});
            @(negedge clk);
            lkp_ack = 1; lkp_hit = hit[0];
            lkp_data = mkdata(en * 8 + tg * 2 + hit + 7); lkp_meta = MW'(tg * 37 + hit * 5 + 3);
            @(negedge clk);
            lkp_ack = 0; lkp_data = '0; lkp_meta = '0;
            if (hit == 0) begin
              // R8
              check("R8 no write", pw_req, 0);
              reg_rd(0, rd); check("R8 fail status", rd, 64'h40 | 64'(tg << 2) | 64'h1);
            end else begin
              // R7
              if (tg == 1)
                for (int c = 0; c < NC; c++) expc[c] = ~^mkdata(en * 8 + tg * 2 + hit + 7)[c*CWB +: CWB];
              else begin
                expc = '0; expc[0] = ~^MW'(tg * 37 + hit * 5 + 3);
              end
              check("R7 pw_req", pw_req, 1);
              check("R7 pw_sel", pw_sel, tg[0]);
              check("R7 pw_code", pw_code, expc);
              @(negedge clk);
              check("R7 pw hold", {pw_req, pw_code}, {1'b1, expc});
              pw_ack = 1;
              @(negedge clk);
              pw_ack = 0;
              check("R7 pw drop", pw_req, 0);
              reg_rd(0, rd); check("R7 ok status", rd, 64'h20 | 64'(tg << 2) | 64'h1);
            end
          end
        end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule